// File: doc/BRIEF.md
# Paired Pulse Generator with Staged Reload

This block is a pair of pulse generator channels. Each channel makes a rectangular wave whose low time and high time are programmed through two reload bytes. A down-counter takes the low count when a period starts and the high count when the low phase runs out. The pair can run as two separate 8-bit generators. It can also run as one 16-bit generator, where channel 1 supplies the upper byte of every count and channel 0 the lower byte.

Software writes the four reload bytes through a 32-bit write port with one enable per byte. Bytes 0 and 1 are the low and high reload of channel 0. Bytes 2 and 3 are the low and high reload of channel 1. A channel samples both of its reload bytes together at the start of every period, so a bus cycle that writes both bytes changes the period as a unit.

In cascaded mode, writes to channel 0 go into a staging register. That register moves into channel 0's reload when channel 1 is written, so the 16-bit reload value changes in one step. A write of all four bytes stages the channel 0 half and commits it in the same cycle.

Top module: `ppg_pair_reload`

## Requirements
- R1: A synchronous active-high `rst` clears both reload registers, the staging register and the counters, and drives `wave0` and `wave1` low; `bus_rdata` reads 0 afterwards.
- R2: In 8-bit mode, an enabled channel with low reload L and high reload H outputs L+1 clocks low followed by H+1 clocks high, and repeats this period.
- R3: In 8-bit mode, a byte write to either channel lands in that channel's reload register in the cycle after the write, leaves the other channel untouched, and is visible on `bus_rdata` (`{ch1 high, ch1 low, ch0 high, ch0 low}` from bit 31 down).
- R4: Both reload bytes are sampled only at the start of a period. A low byte written before a period start, followed by a high byte written after it, gives exactly one period with the new low count and the old high count.
- R5: When both bytes of a channel are written in one bus cycle during a period, the current period completes with the old values and the next period uses both new values.
- R6: In cascaded mode, a write that touches only bytes 0 and 1 goes to the staging register. Channel 0's reload register, `bus_rdata` and the output period stay unchanged.
- R7: In cascaded mode, a write that touches byte 2 or 3 updates channel 1 and, in the same cycle, copies the staging register (merged with any channel 0 bytes of that same write) into channel 0's reload register.
- R8: In cascaded mode, a single write with all four byte enables set gives the same result as a channel 0 write followed by a channel 1 write.
- R9: In cascaded mode, the low phase lasts {ch1 low, ch0 low}+1 clocks and the high phase {ch1 high, ch0 high}+1 clocks, enabled by `ch_en[0]`; both outputs carry this wave.
- R10: A disabled channel holds its output low. After it is enabled, it always starts with a full low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cascade | input | 1 | 1 selects the single 16-bit generator |
| ch_en | input | 2 | Per-channel run enable (bit 0 also runs the 16-bit generator) |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables: 0 ch0 low, 1 ch0 high, 2 ch1 low, 3 ch1 high |
| bus_wdata | input | 32 | Write data, byte lanes as for bus_be |
| bus_rdata | output | 32 | Active reload registers, same lanes |
| wave0 | output | 1 | Channel 0 output, or the 16-bit wave |
| wave1 | output | 1 | Channel 1 output, or the 16-bit wave |

## Verification
The bench targets the split-write window. It writes the low byte during a high phase and the high byte just after the next period start. A design that samples the high count at the low-to-high transition would show the new high count at once, not one period late. It also writes both bytes in mid-period, which catches a design that applies half of the write early. In cascaded mode the bench checks that a lone channel 0 write changes neither the read-back nor the period, which catches a missing staging register. The four-byte write catches a design that commits the old staging contents instead of the merged data.

// File: rtl/ppg_pair_reload.sv
module ppg_pair_reload #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cascade,
  input  logic [1:0]      ch_en,
  input  logic            bus_we,
  input  logic [3:0]      bus_be,
  input  logic [4*BW-1:0] bus_wdata,
  output logic [4*BW-1:0] bus_rdata,
  output logic            wave0,
  output logic            wave1
);
  localparam int RW = 2*BW;

  logic [1:0][RW-1:0] rel;
  logic [RW-1:0]      stage, stage_nx, lo16, hi16;
  logic [1:0][BW-1:0] cnt, hh;
  logic [1:0]         run, lvl;

  assign stage_nx[BW-1:0]  = bus_be[0] ? bus_wdata[BW-1:0]  : stage[BW-1:0];
  assign stage_nx[RW-1:BW] = bus_be[1] ? bus_wdata[RW-1:BW] : stage[RW-1:BW];
  assign lo16      = {rel[1][BW-1:0],  rel[0][BW-1:0]};
  assign hi16      = {rel[1][RW-1:BW], rel[0][RW-1:BW]};
  assign bus_rdata = rel;
  assign wave0     = lvl[0];
  assign wave1     = cascade ? lvl[0] : lvl[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rel   <= '0;
      stage <= '0;
    end else if (bus_we) begin
      if (cascade) begin
        stage <= stage_nx;
        if (|bus_be[3:2]) rel[0] <= stage_nx;
      end else begin
        if (bus_be[0]) rel[0][BW-1:0]  <= bus_wdata[BW-1:0];
        if (bus_be[1]) rel[0][RW-1:BW] <= bus_wdata[RW-1:BW];
      end
      if (bus_be[2]) rel[1][BW-1:0]  <= bus_wdata[RW+BW-1:RW];
      if (bus_be[3]) rel[1][RW-1:BW] <= bus_wdata[4*BW-1:RW+BW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      hh  <= '0;
      run <= '0;
      lvl <= '0;
    end else if (cascade) begin
      run[1] <= 1'b0;
      lvl[1] <= 1'b0;
      if (!ch_en[0]) begin
        run[0] <= 1'b0;
        lvl[0] <= 1'b0;
      end else if (!run[0] || (lvl[0] && cnt == '0)) begin
        run[0] <= 1'b1;
        lvl[0] <= 1'b0;
        cnt    <= lo16;
        hh     <= hi16;
      end else if (cnt != '0) begin
        cnt <= cnt - RW'(1);
      end else begin
        lvl[0] <= 1'b1;
        cnt    <= hh;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (!ch_en[i]) begin
          run[i] <= 1'b0;
          lvl[i] <= 1'b0;
        end else if (!run[i] || (lvl[i] && cnt[i] == '0)) begin
          run[i] <= 1'b1;
          lvl[i] <= 1'b0;
          cnt[i] <= rel[i][BW-1:0];
          hh[i]  <= rel[i][RW-1:BW];
        end else if (cnt[i] != '0) begin
          cnt[i] <= cnt[i] - BW'(1);
        end else begin
          lvl[i] <= 1'b1;
          cnt[i] <= hh[i];
        end
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0 && !wave0 && !wave1)); // R1
  AST_DIRECT_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
    (!cascade && bus_we && bus_be[0]) |=> rel[0][BW-1:0] == $past(bus_wdata[BW-1:0])); // R3
  AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cascade && bus_we && bus_be[3:2] == 2'b00) |=> $stable(rel[0])); // R6
  AST_STAGE_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (cascade && bus_we && bus_be[3:2] == 2'b11) |=>
      (rel[0] == $past(stage_nx) && rel[1] == $past(bus_wdata[4*BW-1:RW]))); // R7
  AST_NO_EARLY_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (!cascade && run[0] && ch_en[0] && cnt[0] != '0) |=> wave0 == $past(wave0)); // R2
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!cascade && !ch_en[1]) |=> (cascade || !wave1)); // R10
endmodule

// File: tb/ppg_pair_reload_tb.sv
module ppg_pair_reload_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cascade = 1'b0;
  logic [1:0]  ch_en = 2'b00;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wave0, wave1;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ppg_pair_reload dut_i (
    .clk(clk), .rst(rst), .cascade(cascade), .ch_en(ch_en),
    .bus_we(bus_we), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wave0(wave0), .wave1(wave1)
  );

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic pin(int sel);
    return sel != 0 ? wave1 : wave0;
  endfunction

  task automatic wr(logic [3:0] be, logic [31:0] d);
    bus_we = 1'b1; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_be = 4'h0;
  endtask

  task automatic wait_fall(int sel);
    while (!pin(sel)) @(negedge clk);
    while (pin(sel)) @(negedge clk);
  endtask

  task automatic wait_rise(int sel);
    while (pin(sel)) @(negedge clk);
    while (!pin(sel)) @(negedge clk);
  endtask

  task automatic meas(int sel, int n0, output int lo, output int hi);
    lo = n0;
    @(negedge clk);
    while (!pin(sel)) begin lo++; @(negedge clk); end
    hi = 0;
    while (pin(sel)) begin hi++; @(negedge clk); end
  endtask

  task automatic t_reset(logic casc);
    rst = 1'b1; ch_en = 2'b00; bus_we = 1'b0; cascade = casc;
    repeat (2) @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 0);
    check("R1 outputs after reset", {wave1, wave0}, 0);
    rst = 1'b0;
  endtask

  task automatic t_basic8();
    int lo, hi;
    wr(4'b0011, 32'h0000_0302);
    check("R3 ch0 word write", bus_rdata, 32'h0000_0302);
    ch_en = 2'b01;
    @(negedge clk);
    check("R10 starts low", wave0, 0);
    wait_fall(0);
    meas(0, 1, lo, hi);
    check("R2 low length", lo, 3);
    check("R2 high length", hi, 4);
    meas(0, 1, lo, hi);
    check("R2 repeat period", {lo[15:0], hi[15:0]}, {16'd3, 16'd4});
  endtask

  task automatic t_indep();
    int lo, hi;
    wr(4'b1100, 32'h0104_0000);
    check("R3 ch1 write leaves ch0", bus_rdata, 32'h0104_0302);
    ch_en = 2'b11;
    wait_fall(1);
    meas(1, 1, lo, hi);
    check("R3 ch1 period", {lo[15:0], hi[15:0]}, {16'd5, 16'd2});
    wait_fall(0);
    meas(0, 1, lo, hi);
    check("R3 ch0 period unchanged", {lo[15:0], hi[15:0]}, {16'd3, 16'd4});
  endtask

  task automatic t_split();
    int lo, hi;
    wait_rise(0);
    wr(4'b0001, 32'h0000_0006);
    wait_fall(0);
    wr(4'b0010, 32'h0000_0700);
    meas(0, 2, lo, hi);
    check("R4 mixed period", {lo[15:0], hi[15:0]}, {16'd7, 16'd4});
    meas(0, 1, lo, hi);
    check("R4 following period", {lo[15:0], hi[15:0]}, {16'd7, 16'd8});
  endtask

  task automatic t_atomic();
    int lo, hi;
    wait_fall(0);
    wr(4'b0011, 32'h0000_0102);
    meas(0, 2, lo, hi);
    check("R5 current period old", {lo[15:0], hi[15:0]}, {16'd7, 16'd8});
    meas(0, 1, lo, hi);
    check("R5 next period new", {lo[15:0], hi[15:0]}, {16'd3, 16'd2});
  endtask

  task automatic t_disable();
    int bad = 0;
    ch_en = 2'b10;
    repeat (6) begin
      @(negedge clk);
      if (wave0) bad++;
    end
    check("R10 disabled output low", bad, 0);
    ch_en = 2'b11;
    @(negedge clk);
    check("R10 restart low", wave0, 0);
  endtask

  task automatic t_cascade();
    int lo, hi;
    t_reset(1'b1);
    wr(4'b0011, 32'h0000_0102);
    check("R6 ch0 write staged", bus_rdata, 0);
    wr(4'b1100, 32'h0001_0000);
    check("R7 commit on ch1 write", bus_rdata, 32'h0001_0102);
    ch_en = 2'b01;
    wait_fall(0);
    meas(0, 1, lo, hi);
    check("R9 16-bit period", {lo[15:0], hi[15:0]}, {16'd259, 16'd2});
    wr(4'b0011, 32'h0000_0505);
    check("R6 rdata unchanged", bus_rdata, 32'h0001_0102);
    meas(0, 2, lo, hi);
    meas(0, 1, lo, hi);
    check("R6 period unchanged", {lo[15:0], hi[15:0]}, {16'd259, 16'd2});
    check("R9 wave1 mirrors", wave1, wave0);
  endtask

  task automatic t_long();
    int lo, hi;
    wr(4'b1111, 32'h0000_0405);
    check("R8 long write rdata", bus_rdata, 32'h0000_0405);
    meas(0, 2, lo, hi);
    meas(0, 1, lo, hi);
    check("R8 long write period", {lo[15:0], hi[15:0]}, {16'd6, 16'd5});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset(1'b0);
    t_basic8();
    t_indep();
    t_split();
    t_atomic();
    t_disable();
    t_cascade();
    t_long();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule